// File: doc/BRIEF.md
# Bit-Sliced Ripple ALU with Subtract

This block is a 32-bit combinational arithmetic-logic unit made of identical one-bit slices. Every slice holds an AND gate, an OR gate and a full adder, and a small selector passes one of the three onto that bit of the result. The carry produced by each slice feeds the next slice up, so the add path is a single ripple chain from bit 0 to bit 31. The carry leaving the top slice is brought out as the carry output.

Subtraction has no opcode of its own. Two separate controls produce it. The invert control makes every slice use the complement of its B bit. The carry input of the lowest slice supplies the extra one that two's complement negation needs. With the adder selected and both controls high, the block computes A plus the complement of B plus one, which equals A minus B. The same two controls with A held at zero negate B.

A datapath uses the block as its main integer unit. It drives the operands, the two-bit operation code, the invert control and the carry input in one cycle, and the result and carry can be used in that same cycle.

Top module: `ripple_alu`

## Requirements
- R1: With op code 0 (logical AND) and invert low, every result bit is A AND B.
- R2: With op code 1 (logical OR) and invert low, every result bit is A OR B.
- R3: With op code 2 (sum) and invert low, the 33-bit value {carry out, result} equals A + B + carry in.
- R4: With invert high, every slice uses the complement of its B bit for all operations. With op 0 the result is A AND NOT B, and with op 1 it is A OR NOT B.
- R5: With op 2, invert high and carry in high, the result is A − B modulo 2^32. The carry out is 1 exactly when A ≥ B as unsigned numbers.
- R6: Op code 3 is reserved and forces every result bit to 0.
- R7: For every op code, the carry out is the carry leaving slice 31 of the add chain. That carry is the top bit of A + B' + carry in, where B' is B, or NOT B when invert is high.
- R8: A carry entering slice 0 propagates through all 32 slices. For A = 0xFFFFFFFF, B = 0 and carry in 1, op 2 gives result 0 and carry out 1.
- R9: Negation works with A = 0, invert high and carry in high under op 2. B = 0xFFFFFFFC (−4) gives 0x00000004, and applying the same steps to that result gives 0xFFFFFFFC again.
- R10: The block holds no state. Result and carry out follow a change of inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B, before optional inversion |
| op_i | input | 2 | Operation: 0 AND, 1 OR, 2 sum, 3 reserved |
| b_inv_i | input | 1 | Use the complement of B in every slice |
| c_in_i | input | 1 | Carry into slice 0 |
| res_o | output | 32 | Result |
| c_out_o | output | 1 | Carry leaving slice 31 |

## Verification
The hardest case to reach from the ports is a carry that ripples through all 32 slices. It occurs only when every slice propagates, meaning each bit of A differs from the effective B bit, and a carry enters at the bottom. The stimulus reaches it in two ways: all-ones A plus a carry in, and subtracting equal operands, where NOT B complements A everywhere. The negation round trip feeds one result back in as the next B operand. This checks that invert and carry in together form a true two's complement and not only a one's complement.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_SUM  = 2'd2,
        OP_RSVD = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic and_b;
        logic or_b;
        logic sum_b;
    } slice_res_t;

    function automatic logic pick_bit(input alu_op_e op, input slice_res_t r);
        logic y;
        case (op)
            OP_AND:  y = r.and_b;
            OP_OR:   y = r.or_b;
            OP_SUM:  y = r.sum_b;
            default: y = 1'b0;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half_s;

    assign half_s = x_i ^ y_i;
    assign s_o    = half_s ^ c_i;
    assign c_o    = (x_i & y_i) | (half_s & c_i);

endmodule

// File: rtl/alu_bit_mux.sv
module alu_bit_mux
    import ralu_pkg::*;
(
    input  alu_op_e    op_i,
    input  slice_res_t cand_i,
    output logic       y_o
);
    assign y_o = pick_bit(op_i, cand_i);
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import ralu_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    input  logic    b_inv_i,
    input  logic    c_i,
    input  alu_op_e op_i,
    output logic    y_o,
    output logic    c_o
);
    logic       b_eff;
    slice_res_t cand;

    assign b_eff       = b_inv_i ? ~b_i : b_i;
    assign cand.and_b  = a_i & b_eff;
    assign cand.or_b   = a_i | b_eff;

    alu_full_adder u_fa (
        .x_i (a_i),
        .y_i (b_eff),
        .c_i (c_i),
        .s_o (cand.sum_b),
        .c_o (c_o)
    );

    alu_bit_mux u_mux (
        .op_i   (op_i),
        .cand_i (cand),
        .y_o    (y_o)
    );

    always_comb begin
        if (!$isunknown({a_i, b_i, b_inv_i, c_i})) begin
            // R7
            slice_kill_gen_chk: assert ((a_i == (b_inv_i ? ~b_i : b_i)) -> (c_o == a_i))
                else $error("slice carry not generated/killed by equal inputs");
        end
    end

endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
    import ralu_pkg::*;
#(
    parameter int WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             b_inv_i,
    input  logic             c_in_i,
    output logic [WIDTH-1:0] res_o,
    output logic             c_out_o
);
    localparam int CHAIN_W = WIDTH + 1;

    alu_op_e            op;
    logic [CHAIN_W-1:0] carry;

    assign op       = alu_op_e'(op_i);
    assign carry[0] = c_in_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_bit_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .b_inv_i (b_inv_i),
            .c_i     (carry[i]),
            .op_i    (op),
            .y_o     (res_o[i]),
            .c_o     (carry[i+1])
        );
    end

    assign c_out_o = carry[WIDTH];

    always_comb begin
        if (!$isunknown({a_i, b_i, op_i, b_inv_i, c_in_i})) begin
            // R3
            add_path_chk: assert (!(op_i == 2'd2 && !b_inv_i) ||
                                  ({c_out_o, res_o} == ({1'b0, a_i} + {1'b0, b_i} + CHAIN_W'(c_in_i))))
                else $error("sum mismatch");
            // R5
            sub_path_chk: assert (!(op_i == 2'd2 && b_inv_i && c_in_i) ||
                                  (res_o == WIDTH'(a_i - b_i) && c_out_o == (a_i >= b_i)))
                else $error("difference mismatch");
            // R6
            rsvd_zero_chk: assert (op_i != 2'd3 || res_o == '0)
                else $error("reserved op result not zero");
            // R1
            and_path_chk: assert (!(op_i == 2'd0 && !b_inv_i) || ((res_o | (a_i & b_i)) == (a_i & b_i)))
                else $error("and result has extra bits");
        end
    end

endmodule

// File: tb/sim_ripple_alu.sv
module sim_ripple_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [1:0]   op;
        logic         inv;
        logic         cin;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{32'hF0F0_A5A5, 32'h0FF0_3C3C, 2'd0, 1'b0, 1'b0},
        '{32'hFFFF_FFFF, 32'h1234_5678, 2'd0, 1'b0, 1'b1},
        '{32'hF0F0_A5A5, 32'h0FF0_3C3C, 2'd1, 1'b0, 1'b0},
        '{32'h0000_0000, 32'h8000_0001, 2'd1, 1'b0, 1'b0},
        '{32'h0000_0007, 32'h0000_0002, 2'd2, 1'b0, 1'b0},
        '{32'h8000_0000, 32'h8000_0000, 2'd2, 1'b0, 1'b1},
        '{32'h1234_5678, 32'h0F0F_0F0F, 2'd2, 1'b0, 1'b1},
        '{32'hF0F0_A5A5, 32'h0FF0_3C3C, 2'd0, 1'b1, 1'b0},
        '{32'h0000_0000, 32'hFFFF_0000, 2'd1, 1'b1, 1'b0},
        '{32'h0000_0007, 32'h0000_0002, 2'd2, 1'b1, 1'b1},
        '{32'h0000_0002, 32'h0000_0007, 2'd2, 1'b1, 1'b1},
        '{32'hDEAD_BEEF, 32'hDEAD_BEEF, 2'd2, 1'b1, 1'b1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, 1'b0, 1'b1},
        '{32'hFFFF_FFFF, 32'h0000_0001, 2'd3, 1'b1, 1'b0}
    };

    logic         clk;
    logic [W-1:0] a, b, res;
    logic [1:0]   op;
    logic         inv, cin, cout;
    int           checks, fails;

    ripple_alu u0 (
        .a_i     (a),
        .b_i     (b),
        .op_i    (op),
        .b_inv_i (inv),
        .c_in_i  (cin),
        .res_o   (res),
        .c_out_o (cout)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W:0] model(input vec_t v);
        logic [W-1:0] be;
        logic [W:0]   sum;
        logic [W-1:0] r;
        be  = v.inv ? ~v.b : v.b;
        sum = {1'b0, v.a} + {1'b0, be} + (W+1)'(v.cin);
        case (v.op)
            2'd0:    r = v.a & be;
            2'd1:    r = v.a | be;
            2'd2:    r = sum[W-1:0];
            default: r = '0;
        endcase
        return {sum[W], r};
    endfunction

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got cout=%0b res=%h expected cout=%0b res=%h",
                     req, got[W], got[W-1:0], exp[W], exp[W-1:0]);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        a = v.a; b = v.b; op = v.op; inv = v.inv; cin = v.cin;
        #1;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.op == 2'd3) return "R6";
        if (v.inv && v.op != 2'd2) return "R4";
        if (v.inv) return "R5";
        if (v.op == 2'd0) return "R1";
        if (v.op == 2'd1) return "R2";
        return "R3";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        checks = 0; fails = 0;
        a = '0; b = '0; op = 2'd0; inv = 1'b0; cin = 1'b0;
        @(negedge clk); #1;
        // R10: quiet inputs give a zero result with no clock dependence
        check("R10 idle", {cout, res}, 33'h0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            check(tag_of(VECS[i]), {cout, res}, model(VECS[i]));
        end

        // R7: carry out follows the chain even when the result is logical
        v = '{32'hFFFF_FFFF, 32'h0000_0001, 2'd0, 1'b0, 1'b0};
        drive(v);
        check("R7 and-op carry", {cout, res}, {1'b1, 32'h0000_0001});
        v = '{32'h0000_0005, 32'h0000_0005, 2'd1, 1'b1, 1'b1};
        drive(v);
        check("R7 or-op carry", {cout, res}, {1'b1, 32'hFFFF_FFFF});

        // R8: full-length ripple
        v = '{32'hFFFF_FFFF, 32'h0000_0000, 2'd2, 1'b0, 1'b1};
        drive(v);
        check("R8 full ripple", {cout, res}, {1'b1, 32'h0});
        v = '{32'h0000_0000, 32'h0000_0000, 2'd2, 1'b1, 1'b1};
        drive(v);
        check("R8 zero minus zero", {cout, res}, {1'b1, 32'h0});

        // R9: negate -4, then negate the result
        v = '{32'h0, 32'hFFFF_FFFC, 2'd2, 1'b1, 1'b1};
        drive(v);
        check("R9 negate -4", {1'b0, res}, {1'b0, 32'h0000_0004});
        v.b = res;
        drive(v);
        check("R9 negate back", {1'b0, res}, {1'b0, 32'hFFFF_FFFC});
        // invert alone is a one's complement only
        v = '{32'h0, 32'hFFFF_FFFC, 2'd2, 1'b1, 1'b0};
        drive(v);
        check("R9 no +1", {1'b0, res}, {1'b0, 32'h0000_0003});

        // R10: output changes mid-phase without an edge
        @(negedge clk);
        a = 32'h0000_0010; b = 32'h0000_0001; op = 2'd2; inv = 1'b0; cin = 1'b0;
        #1;
        check("R10 first", {cout, res}, {1'b0, 32'h0000_0011});
        b = 32'h0000_0020;
        #1;
        check("R10 no edge", {cout, res}, {1'b0, 32'h0000_0030});

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule